// File: doc/BRIEF.md
# Dual-Adder Interlocked Add Pipeline

This block runs a stream of register-to-register add operations through four stages: fetch, decode, execute and write-back. Each operation names a destination and two source registers. Decode holds an operation until both of its sources hold final values and an adder is free. While decode holds, fetch takes nothing new from the input. Two adders take work. Neither is pipelined, and an add occupies one for three cycles. Each adder then writes its result through a register-file write port of its own in the following cycle.

The only path from a result to a waiting operation is the register file. A write lands early in a cycle, and decode reads the new value later in that same cycle. A scoreboard marks each destination as pending from the cycle its producer leaves decode. The mark is removed when that producer writes. It is not removed by an older writer of the same register. The block reports every register write on its ports, raises a stall flag while decode is held, and keeps a running count of completed operations.

Top module: `ia_add_pipe`

## Requirements
- R1: After reset, no write port is active, stall is low, the retire count is zero, and register i holds the value i+1.
- R2: An operation fetched in cycle f with no hazard is decoded in cycle f+1, leaves decode at the end of that cycle, and writes dst = (src_a + src_b) mod 2^DATA_W in cycle f+5. The operation is fetched in a cycle where in_valid is high and stall is low.
- R3: An operation whose source is pending leaves decode in the cycle its producer writes back, and not earlier. It reads the newly written value in that same cycle.
- R4: A value still inside an adder is never passed to decode. A dependent operation always waits for the register-file write.
- R5: An adder stays busy for exactly three cycles after it takes an operation. It can take another operation during its own write-back cycle. When both adders are busy, decode holds.
- R6: While stall is high, the input operation is not accepted. It is accepted in the first cycle that stall is low.
- R7: When two operations in flight target the same register, a reader of that register waits for the younger one's write.
- R8: The retire count goes up by the number of writes in each cycle.
- R9: stall is high exactly when decode holds an operation that does not leave at the end of the cycle. The held operation stays unchanged.
- R10: The lower-numbered free adder is chosen. Adder u writes only through write port u. Port u has bits [u*ADDR_W +: ADDR_W] of wb_addr and bits [u*DATA_W +: DATA_W] of wb_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered on the input fields |
| in_dst | input | ADDR_W | Destination register of the offered operation |
| in_src_a | input | ADDR_W | First source register |
| in_src_b | input | ADDR_W | Second source register |
| stall | output | 1 | Decode is held this cycle and the input is not taken |
| wb_en | output | NUM_ADD | Per-port register write strobe |
| wb_addr | output | NUM_ADD*ADDR_W | Per-port written register index |
| wb_data | output | NUM_ADD*DATA_W | Per-port written value |
| retire_count | output | RET_W | Number of completed operations since reset |

## Verification
The case that needs care is when a write-back and the decode of that register's reader happen in the same cycle. The reader must leave decode in that cycle and capture the value being written, not the old one. Dependence chains set this up, and a pair of writes to one register followed by a reader sets up the version where an older write must not release the reader. A second case is an adder that finishes while a new operation is assigned to it in the same cycle. Back-to-back independent streams fill both adders to set this up. The bench first works out, on its own, the fetch cycle of every operation and the cycle and port of every write. Each observed write and each accept cycle is then compared with that schedule.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int IA_NUM_REGS = 16;
  localparam int IA_DATA_W   = 16;
  localparam int IA_NUM_ADD  = 2;
  localparam int IA_ADD_LAT  = 3;
  localparam int IA_RET_W    = 16;

  // value every register takes at reset
  function automatic logic [63:0] seed_word(input int unsigned idx);
    return 64'(idx) + 64'd1;
  endfunction

  // index width that never collapses to zero bits
  function automatic int safe_clog2(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ia_regfile.sv
module ia_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_WR   = 2,
  localparam int AW      = ia_pkg::safe_clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WR-1:0]        we,
  input  logic [NUM_WR*AW-1:0]     waddr,
  input  logic [NUM_WR*DATA_W-1:0] wdata,
  input  logic [AW-1:0]            raddr_a,
  input  logic [AW-1:0]            raddr_b,
  output logic [DATA_W-1:0]        rdata_a,
  output logic [DATA_W-1:0]        rdata_b
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) mem[r] <= DATA_W'(ia_pkg::seed_word(r));
    end else begin
      for (int w = 0; w < NUM_WR; w++)
        if (we[w]) mem[waddr[w*AW +: AW]] <= wdata[w*DATA_W +: DATA_W];
    end
  end

  // write-then-read within one cycle: a live write wins over the stored word
  always_comb begin
    rdata_a = mem[raddr_a];
    rdata_b = mem[raddr_b];
    for (int w = 0; w < NUM_WR; w++) begin
      if (we[w] && waddr[w*AW +: AW] == raddr_a) rdata_a = wdata[w*DATA_W +: DATA_W];
      if (we[w] && waddr[w*AW +: AW] == raddr_b) rdata_b = wdata[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/ia_scoreboard.sv
module ia_scoreboard #(
  parameter int NUM_REGS = 16,
  parameter int NUM_ADD  = 2,
  localparam int AW      = ia_pkg::safe_clog2(NUM_REGS),
  localparam int UW      = ia_pkg::safe_clog2(NUM_ADD)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [AW-1:0]         set_addr,
  input  logic [UW-1:0]         set_unit,
  input  logic [NUM_ADD-1:0]    clr_en,
  input  logic [NUM_ADD*AW-1:0] clr_addr,
  input  logic [AW-1:0]         query_a,
  input  logic [AW-1:0]         query_b,
  output logic                  ready_a,
  output logic                  ready_b,
  output logic [NUM_REGS-1:0]   pending
);
  logic [UW-1:0]       owner [NUM_REGS];
  logic [NUM_REGS-1:0] release_now;

  // only the adder that holds the newest claim may release a register
  always_comb begin
    release_now = '0;
    for (int r = 0; r < NUM_REGS; r++)
      for (int u = 0; u < NUM_ADD; u++)
        if (clr_en[u] && clr_addr[u*AW +: AW] == AW'(r) && owner[r] == UW'(u))
          release_now[r] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (set_en && set_addr == AW'(r)) begin
          pending[r] <= 1'b1;
          owner[r]   <= set_unit;
        end else if (release_now[r]) begin
          pending[r] <= 1'b0;
        end
      end
    end
  end

  assign ready_a = !pending[query_a] || release_now[query_a];
  assign ready_b = !pending[query_b] || release_now[query_b];

  // R7: a new claim is visible as pending in the next cycle
  a_r7_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pending[$past(set_addr)]);
endmodule

// File: rtl/ia_exec_unit.sv
module ia_exec_unit #(
  parameter int DATA_W  = 16,
  parameter int AW      = 4,
  parameter int ADD_LAT = 3,
  localparam int CW     = ia_pkg::safe_clog2(ADD_LAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     dst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              busy,
  output logic              wb_en,
  output logic [AW-1:0]     wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  logic [CW-1:0]     step;
  logic [AW-1:0]     hold_dst;
  logic [DATA_W-1:0] hold_sum;
  logic              last_step;

  assign last_step = busy && (step == CW'(ADD_LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step     <= '0;
      hold_dst <= '0;
      hold_sum <= '0;
      wb_en    <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      wb_en <= last_step;
      if (last_step) begin
        wb_addr <= hold_dst;
        wb_data <= hold_sum;
      end
      if (start) begin
        busy     <= 1'b1;
        step     <= '0;
        hold_dst <= dst;
        hold_sum <= op_a + op_b;
      end else if (last_step) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + CW'(1);
      end
    end
  end

  // R5: never handed work while occupied
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R5: occupancy advances one step per cycle
  a_r5_busy_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy && step == $past(step) + CW'(1));
  // R5: the write follows the final execute cycle
  a_r5_write_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> wb_en);
endmodule

// File: rtl/ia_add_pipe.sv
module ia_add_pipe #(
  parameter int NUM_REGS = ia_pkg::IA_NUM_REGS,
  parameter int DATA_W   = ia_pkg::IA_DATA_W,
  parameter int NUM_ADD  = ia_pkg::IA_NUM_ADD,
  parameter int ADD_LAT  = ia_pkg::IA_ADD_LAT,
  parameter int RET_W    = ia_pkg::IA_RET_W,
  localparam int ADDR_W  = ia_pkg::safe_clog2(NUM_REGS),
  localparam int UW      = ia_pkg::safe_clog2(NUM_ADD)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ADDR_W-1:0]         in_dst,
  input  logic [ADDR_W-1:0]         in_src_a,
  input  logic [ADDR_W-1:0]         in_src_b,
  output logic                      stall,
  output logic [NUM_ADD-1:0]        wb_en,
  output logic [NUM_ADD*ADDR_W-1:0] wb_addr,
  output logic [NUM_ADD*DATA_W-1:0] wb_data,
  output logic [RET_W-1:0]          retire_count
);
  // decode stage
  logic              dec_valid;
  logic [ADDR_W-1:0] dec_dst, dec_sa, dec_sb;

  logic               src_a_ok, src_b_ok;
  logic [DATA_W-1:0]  opnd_a, opnd_b;
  logic [NUM_ADD-1:0] unit_busy;
  logic [UW-1:0]      pick;
  logic               any_free;
  logic               issue;
  logic               accept;
  logic [NUM_REGS-1:0] pend_vec;

  always_comb begin
    pick     = '0;
    any_free = 1'b0;
    for (int u = NUM_ADD - 1; u >= 0; u--)
      if (!unit_busy[u]) begin
        pick     = UW'(u);
        any_free = 1'b1;
      end
  end

  assign issue  = dec_valid && src_a_ok && src_b_ok && any_free;
  assign stall  = dec_valid && !issue;
  assign accept = in_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_dst   <= '0;
      dec_sa    <= '0;
      dec_sb    <= '0;
    end else if (accept) begin
      dec_valid <= 1'b1;
      dec_dst   <= in_dst;
      dec_sa    <= in_src_a;
      dec_sb    <= in_src_b;
    end else if (issue) begin
      dec_valid <= 1'b0;
    end
  end

  ia_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_WR(NUM_ADD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
    .raddr_a(dec_sa), .raddr_b(dec_sb),
    .rdata_a(opnd_a), .rdata_b(opnd_b)
  );

  ia_scoreboard #(.NUM_REGS(NUM_REGS), .NUM_ADD(NUM_ADD)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue), .set_addr(dec_dst), .set_unit(pick),
    .clr_en(wb_en), .clr_addr(wb_addr),
    .query_a(dec_sa), .query_b(dec_sb),
    .ready_a(src_a_ok), .ready_b(src_b_ok),
    .pending(pend_vec)
  );

  for (genvar gu = 0; gu < NUM_ADD; gu++) begin : g_add
    ia_exec_unit #(.DATA_W(DATA_W), .AW(ADDR_W), .ADD_LAT(ADD_LAT)) u_exec (
      .clk(clk), .rst_n(rst_n),
      .start(issue && pick == UW'(gu)),
      .dst(dec_dst), .op_a(opnd_a), .op_b(opnd_b),
      .busy(unit_busy[gu]),
      .wb_en(wb_en[gu]),
      .wb_addr(wb_addr[gu*ADDR_W +: ADDR_W]),
      .wb_data(wb_data[gu*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) retire_count <= '0;
    else        retire_count <= retire_count + RET_W'($countones(wb_en));
  end

  // R9: a held operation stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> dec_valid && $stable({dec_dst, dec_sa, dec_sb}));
  // R8: count follows the number of writes
  a_r8_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> retire_count == $past(retire_count) + RET_W'($countones($past(wb_en))));
  // R10: in-order single issue keeps write cycles distinct
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_en));
  // R6: input never taken while held
  a_r6_no_take_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && in_valid) |=> dec_valid && $stable(dec_dst));
endmodule

// File: tb/test_ia_add_pipe.sv
`timescale 1ns/1ps
module test_ia_add_pipe;
  localparam int NR = 16;
  localparam int DW = 16;
  localparam int NU = 2;
  localparam int AW = 4;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic stall;
  logic [NU-1:0] wb_en;
  logic [NU*AW-1:0] wb_addr;
  logic [NU*DW-1:0] wb_data;
  logic [RW-1:0] retire_count;

  always #2.5 clk = ~clk;

  ia_add_pipe i_ia_add_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .stall(stall), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .retire_count(retire_count)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // write log filled by a monitor at falling edges
  int lg_c[64], lg_u[64], lg_a[64], lg_d[64];
  int lg_n = 0;
  bit logging = 0;
  always @(negedge clk) begin
    if (rst_n && logging)
      for (int u = 0; u < NU; u++)
        if (wb_en[u] && lg_n < 64) begin
          lg_c[lg_n] = cyc; lg_u[lg_n] = u;
          lg_a[lg_n] = int'(wb_addr[u*AW +: AW]);
          lg_d[lg_n] = int'(wb_data[u*DW +: DW]);
          lg_n++;
        end
  end

  // program and bench-side model
  int p_n;
  int p_d[8], p_a[8], p_b[8];
  int ex_f[8], ex_dec[8], ex_u[8], ex_v[8];
  int model[NR];

  task automatic reset_dut();
    in_valid = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < NR; r++) model[r] = r + 1;
    @(negedge clk);
    chk(wb_en == '0, "R1", "write strobes after reset", wb_en, 0);
    chk(stall == 1'b0, "R1", "stall after reset", stall, 0);
    chk(retire_count == '0, "R1", "retire count after reset", retire_count, 0);
  endtask

  // schedule: decode can read a register in its write cycle; an adder
  // taken in cycle d is free again, and writes, in cycle d+4
  task automatic plan(input int first_fetch);
    int ready_at[NR];
    int free_at[NU];
    int f, d, lo;
    for (int r = 0; r < NR; r++) ready_at[r] = 0;
    for (int u = 0; u < NU; u++) free_at[u] = 0;
    f = first_fetch;
    for (int k = 0; k < p_n; k++) begin
      d = f + 1;
      if (ready_at[p_a[k]] > d) d = ready_at[p_a[k]];
      if (ready_at[p_b[k]] > d) d = ready_at[p_b[k]];
      lo = free_at[0];
      for (int u = 1; u < NU; u++) if (free_at[u] < lo) lo = free_at[u];
      if (lo > d) d = lo;
      ex_u[k] = -1;
      for (int u = NU - 1; u >= 0; u--) if (free_at[u] <= d) ex_u[k] = u;
      ex_f[k] = f;
      ex_dec[k] = d;
      free_at[ex_u[k]] = d + 4;
      ready_at[p_d[k]] = d + 4;
      ex_v[k] = (model[p_a[k]] + model[p_b[k]]) % 65536;
      model[p_d[k]] = ex_v[k];
      f = d;
    end
  endtask

  task automatic run_prog(input string tag);
    int spins;
    int hit;
    lg_n = 0;
    logging = 1;
    plan(cyc);
    for (int k = 0; k < p_n; k++) begin
      in_valid = 1;
      in_dst = AW'(p_d[k]); in_src_a = AW'(p_a[k]); in_src_b = AW'(p_b[k]);
      spins = 0;
      while (stall !== 1'b0 && spins < 40) begin
        @(negedge clk);
        spins++;
      end
      // R6 R9: accept cycle reflects every hold of the previous operation
      chk(cyc == ex_f[k], "R6", {tag, " accept cycle"}, cyc, ex_f[k]);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (12) @(negedge clk);
    logging = 0;
    for (int k = 0; k < p_n; k++) begin
      hit = -1;
      for (int e = 0; e < lg_n; e++)
        if (lg_c[e] == ex_dec[k] + 4 && lg_u[e] == ex_u[k]) hit = e;
      chk(hit >= 0, "R3", {tag, " write cycle on expected port (R10)"},
          hit, ex_dec[k] + 4);
      if (hit >= 0) begin
        chk(lg_a[hit] == p_d[k], "R10", {tag, " written register"}, lg_a[hit], p_d[k]);
        chk(lg_d[hit] == ex_v[k], "R2", {tag, " written sum"}, lg_d[hit], ex_v[k]);
      end
    end
    chk(lg_n == p_n, "R4", {tag, " number of writes"}, lg_n, p_n);
    chk(int'(retire_count) == p_n, "R8", {tag, " retire count"}, retire_count, p_n);
  endtask

  // independent ops: third must wait for a free adder (R5, R10)
  task automatic t_independent();
    reset_dut();
    p_n = 4;
    p_d = '{1, 4, 7, 10, 0, 0, 0, 0};
    p_a = '{2, 5, 8, 11, 0, 0, 0, 0};
    p_b = '{3, 6, 9, 12, 0, 0, 0, 0};
    run_prog("R5 independent");
  endtask

  // dependence chain: each op leaves decode in its producer's write cycle (R3)
  task automatic t_chain();
    reset_dut();
    p_n = 4;
    p_d = '{5, 3, 6, 9, 0, 0, 0, 0};
    p_a = '{6, 5, 3, 6, 0, 0, 0, 0};
    p_b = '{7, 4, 8, 3, 0, 0, 0, 0};
    run_prog("R3 chain");
  endtask

  // two writers of r5, then a reader: must see the younger (R7)
  task automatic t_double_write();
    reset_dut();
    p_n = 3;
    p_d = '{5, 5, 6, 0, 0, 0, 0, 0};
    p_a = '{1, 3, 5, 0, 0, 0, 0, 0};
    p_b = '{2, 4, 5, 0, 0, 0, 0, 0};
    run_prog("R7 double write");
  endtask

  // mixed stream with a dependence across adders (R2, R9)
  task automatic t_mixed();
    reset_dut();
    p_n = 5;
    p_d = '{3, 8, 4, 7, 12, 0, 0, 0};
    p_a = '{1, 9, 5, 1, 8, 0, 0, 0};
    p_b = '{2, 10, 6, 4, 2, 0, 0, 0};
    run_prog("R9 mixed");
  endtask

  // self-dependent accumulation on one register (R3, R4)
  task automatic t_self();
    reset_dut();
    p_n = 4;
    p_d = '{15, 15, 15, 15, 0, 0, 0, 0};
    p_a = '{15, 15, 15, 15, 0, 0, 0, 0};
    p_b = '{15, 15, 15, 15, 0, 0, 0, 0};
    run_prog("R4 self");
  endtask

  initial begin
    t_independent();
    t_chain();
    t_double_write();
    t_mixed();
    t_self();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule